// File: doc/BRIEF.md
# GPIO Interrupt Line Multiplexer

The block gathers the level interrupt requests of three GPIO banks (14, 24 and 32 lines) and presents them on 41 interrupt-controller inputs. Thirty-eight of these are direct slots, each owned by exactly one source at a time. The other three are shared lines, one per bank. A source is named by the index bank*32 + line, so the valid sources are 0-13, 32-55 and 64-95.

Every direct slot has two candidate sources, and one select bit decides between them. Slot i (0-13) takes bank 0 line i or bank 2 line i. Slot 14+j (0-23) takes bank 1 line j or bank 2 line 14+j. Any line that is not currently routed to a slot is ORed onto its bank's shared output, and a routed line is masked from that output. The select bits live in two 32-bit words of a small register port: 0x54 for slots 0-31 and 0x58 for slots 32-37. Writes take effect at the next rising clock edge. The routing itself is combinational.

Top module: `gpio_irq_concentrator`

## Requirements
- R1: After reset every select bit is 0. Bank 0 lines 0-13 drive slots 0-13, bank 1 lines 0-23 drive slots 14-37, and both configuration words read 0.
- R2: Slot i for i in 0-13 follows bank 0 line i when select bit i is 0 and bank 2 line i when it is 1.
- R3: Slot 14+j follows bank 1 line j when select bit 14+j is 0. When the bit is 1 and 14+j < 32, the slot follows bank 2 line 14+j.
- R4: A slot 32-37 whose select bit is 1 has no bank 2 source. It stays low, and the displaced bank 1 line (18-23) goes to shared output 1.
- R5: shared_irq_o[0] is the OR of the bank 0 lines whose select bit is 1.
- R6: shared_irq_o[1] is the OR of the bank 1 lines j whose select bit 14+j is 1.
- R7: shared_irq_o[2] is the OR of the bank 2 lines k whose select bit k is 0. With all select bits 0, no bank 2 line reaches a direct slot.
- R8: Word 0x54 holds select bits 31:0 and word 0x58 holds bits 37:32 in bits 5:0; bit n controls slot n, and a value of 1 means bank 2. Bits 31:6 of word 0x58 read 0 and are not stored.
- R9: A write to any other address changes no select bit, and a read of any other address returns 0.
- R10: A write changes the routing from the rising clock edge on which it is sampled. Outputs follow the bank inputs without a clock.
- R11: When every bank input is low, every output is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 8 | Register byte address |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data for reg_addr_i |
| bank0_irq_i | input | 14 | Bank 0 level interrupt lines |
| bank1_irq_i | input | 24 | Bank 1 level interrupt lines |
| bank2_irq_i | input | 32 | Bank 2 level interrupt lines |
| direct_irq_o | output | 38 | Direct slot outputs |
| shared_irq_o | output | 3 | Per-bank shared outputs |

## Verification
A select write and a change on the bank inputs can fall in the same cycle. The same source pattern must then follow the old routing before the edge and the new routing after it. The bench provokes this by holding bank 0 line 0 high while a write moves slot 0 to bank 2. It checks that the line sits on slot 0 before the edge and moves to shared output 0 just after it. The bench also sweeps a walking source across all 70 indices and pseudo-random input patterns under several select words. Each output is compared with an arithmetic model of the routing rules.

// File: rtl/irqmux_pkg.sv
package irqmux_pkg;
  function automatic int unsigned div_up(input int unsigned a, input int unsigned b);
    return (a + b - 1) / b;
  endfunction
endpackage

// File: rtl/irqmux_cfg_regs.sv
module irqmux_cfg_regs #(
  parameter int unsigned NUM_SEL   = 38,
  parameter int unsigned DATA_W    = 32,
  parameter int unsigned ADDR_W    = 8,
  parameter int unsigned BASE_ADDR = 'h54
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               we_i,
  input  logic [ADDR_W-1:0]  addr_i,
  input  logic [DATA_W-1:0]  wdata_i,
  output logic [DATA_W-1:0]  rdata_o,
  output logic [NUM_SEL-1:0] sel_o
);
  import irqmux_pkg::*;
  localparam int unsigned NUM_WORDS  = div_up(NUM_SEL, DATA_W);
  localparam int unsigned PAD_W      = NUM_WORDS * DATA_W;
  localparam int unsigned WORD_BYTES = DATA_W / 8;

  logic [NUM_WORDS-1:0] addr_hit;
  logic [NUM_WORDS-1:0] wr_hit;
  logic [PAD_W-1:0]     pad_q;
  logic [PAD_W-1:0]     keep;

  for (genvar w = 0; w < NUM_WORDS; w++) begin : g_dec
    assign addr_hit[w] = (addr_i == ADDR_W'(BASE_ADDR + w * WORD_BYTES));
    assign wr_hit[w]   = we_i && addr_hit[w];
  end

  for (genvar n = 0; n < PAD_W; n++) begin : g_bit
    if (n < NUM_SEL) begin : g_flop
      assign keep[n] = 1'b1;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)                  pad_q[n] <= 1'b0;
        else if (wr_hit[n / DATA_W])  pad_q[n] <= wdata_i[n % DATA_W];
      end
    end else begin : g_tie
      assign keep[n]  = 1'b0;
      assign pad_q[n] = 1'b0;
    end
  end

  always_comb begin
    rdata_o = '0;
    for (int w = 0; w < NUM_WORDS; w++)
      if (addr_hit[w]) rdata_o = pad_q[w*DATA_W +: DATA_W];
  end

  assign sel_o = pad_q[NUM_SEL-1:0];

  assert_reset_default_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rst_ni) |-> (sel_o == '0));
  assert_hold_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(|wr_hit) |=> $stable(pad_q));
  assert_write_land_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_hit[0] |=> (pad_q[DATA_W-1:0] == ($past(wdata_i) & keep[DATA_W-1:0])));
endmodule

// File: rtl/irqmux_slot_route.sv
module irqmux_slot_route #(
  parameter int unsigned B0_W = 14,
  parameter int unsigned B1_W = 24,
  parameter int unsigned B2_W = 32,
  localparam int unsigned ND  = B0_W + B1_W
) (
  input  logic [B0_W-1:0] bank0_i,
  input  logic [B1_W-1:0] bank1_i,
  input  logic [B2_W-1:0] bank2_i,
  input  logic [ND-1:0]   sel_i,
  output logic [ND-1:0]   direct_o
);
  for (genvar s = 0; s < ND; s++) begin : g_slot
    logic pri, alt;
    if (s < B0_W) begin : g_p0
      assign pri = bank0_i[s];
    end else begin : g_p1
      assign pri = bank1_i[s - B0_W];
    end
    if (s < B2_W) begin : g_alt
      assign alt = bank2_i[s];
    end else begin : g_none
      assign alt = 1'b0;   // no bank 2 line for this slot
    end
    assign direct_o[s] = sel_i[s] ? alt : pri;
  end
endmodule

// File: rtl/irqmux_shared_or.sv
module irqmux_shared_or #(
  parameter int unsigned B0_W = 14,
  parameter int unsigned B1_W = 24,
  parameter int unsigned B2_W = 32,
  localparam int unsigned ND  = B0_W + B1_W
) (
  input  logic [B0_W-1:0] bank0_i,
  input  logic [B1_W-1:0] bank1_i,
  input  logic [B2_W-1:0] bank2_i,
  input  logic [ND-1:0]   sel_i,
  output logic [2:0]      shared_o
);
  logic [B2_W-1:0] b2_unrouted;

  for (genvar k = 0; k < B2_W; k++) begin : g_b2
    if (k < ND) begin : g_slot
      assign b2_unrouted[k] = !sel_i[k];
    end else begin : g_noslot
      assign b2_unrouted[k] = 1'b1;
    end
  end

  assign shared_o[0] = |(bank0_i & sel_i[B0_W-1:0]);
  assign shared_o[1] = |(bank1_i & sel_i[ND-1:B0_W]);
  assign shared_o[2] = |(bank2_i & b2_unrouted);
endmodule

// File: rtl/gpio_irq_concentrator.sv
module gpio_irq_concentrator #(
  parameter int unsigned B0_W      = 14,
  parameter int unsigned B1_W      = 24,
  parameter int unsigned B2_W      = 32,
  parameter int unsigned DATA_W    = 32,
  parameter int unsigned ADDR_W    = 8,
  parameter int unsigned BASE_ADDR = 'h54,
  localparam int unsigned ND       = B0_W + B1_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              reg_we_i,
  input  logic [ADDR_W-1:0] reg_addr_i,
  input  logic [DATA_W-1:0] reg_wdata_i,
  output logic [DATA_W-1:0] reg_rdata_o,
  input  logic [B0_W-1:0]   bank0_irq_i,
  input  logic [B1_W-1:0]   bank1_irq_i,
  input  logic [B2_W-1:0]   bank2_irq_i,
  output logic [ND-1:0]     direct_irq_o,
  output logic [2:0]        shared_irq_o
);
  logic [ND-1:0] sel;

  irqmux_cfg_regs #(
    .NUM_SEL(ND), .DATA_W(DATA_W), .ADDR_W(ADDR_W), .BASE_ADDR(BASE_ADDR)
  ) u_cfg (
    .clk_i(clk_i), .rst_ni(rst_ni), .we_i(reg_we_i), .addr_i(reg_addr_i),
    .wdata_i(reg_wdata_i), .rdata_o(reg_rdata_o), .sel_o(sel)
  );

  irqmux_slot_route #(.B0_W(B0_W), .B1_W(B1_W), .B2_W(B2_W)) u_route (
    .bank0_i(bank0_irq_i), .bank1_i(bank1_irq_i), .bank2_i(bank2_irq_i),
    .sel_i(sel), .direct_o(direct_irq_o)
  );

  irqmux_shared_or #(.B0_W(B0_W), .B1_W(B1_W), .B2_W(B2_W)) u_shared (
    .bank0_i(bank0_irq_i), .bank1_i(bank1_irq_i), .bank2_i(bank2_irq_i),
    .sel_i(sel), .shared_o(shared_irq_o)
  );

  assert_quiet_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bank0_irq_i == '0 && bank1_irq_i == '0 && bank2_irq_i == '0)
      |-> (direct_irq_o == '0 && shared_irq_o == '0));
  assert_bank0_visible_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bank0_irq_i & ~(direct_irq_o[B0_W-1:0] | {B0_W{shared_irq_o[0]}})) == '0);

  for (genvar s = B2_W; s < ND; s++) begin : g_tail_chk
    assert_tail_slot_quiet_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      sel[s] |-> !direct_irq_o[s]);
  end
endmodule

// File: tb/gpio_irq_concentrator_tb.sv
module gpio_irq_concentrator_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        we = 1'b0;
  logic [7:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic [13:0] b0 = '0;
  logic [23:0] b1 = '0;
  logic [31:0] b2 = '0;
  logic [37:0] direct;
  logic [2:0]  shared;

  int total = 0;
  int bad   = 0;
  logic [37:0] sel_m = '0;
  logic [31:0] lfsr = 32'h1234_5678;

  always #4 clk = ~clk;   // 125 MHz

  gpio_irq_concentrator dut_i (
    .clk_i(clk), .rst_ni(rst_n), .reg_we_i(we), .reg_addr_i(addr),
    .reg_wdata_i(wdata), .reg_rdata_o(rdata), .bank0_irq_i(b0),
    .bank1_irq_i(b1), .bank2_irq_i(b2), .direct_irq_o(direct), .shared_irq_o(shared)
  );

  function automatic logic [40:0] model(input logic [37:0] s, input logic [13:0] a,
                                        input logic [23:0] b, input logic [31:0] c);
    logic [37:0] d;
    logic [2:0]  sh;
    d = '0; sh = '0;
    for (int i = 0; i < 14; i++) begin
      d[i] = s[i] ? c[i] : a[i];
      if (s[i] && a[i]) sh[0] = 1'b1;
    end
    for (int j = 0; j < 24; j++) begin
      int slot;
      slot = 14 + j;
      if (!s[slot]) d[slot] = b[j];
      else begin
        d[slot] = (slot < 32) ? c[slot] : 1'b0;
        if (b[j]) sh[1] = 1'b1;
      end
    end
    for (int k = 0; k < 32; k++)
      if (!s[k] && c[k]) sh[2] = 1'b1;
    return {sh, d};
  endfunction

  task automatic chk(input string req, input logic [63:0] got, input logic [63:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s got=%h exp=%h", req, got, exp);
    end
  endtask

  task automatic out_chk(input string req);
    #1;
    chk(req, 64'({shared, direct}), 64'(model(sel_m, b0, b1, b2)));
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    addr = a; wdata = d; we = 1'b1;
    @(negedge clk);
    we = 1'b0;
    if (a == 8'h54) sel_m[31:0] = d;
    else if (a == 8'h58) sel_m[37:32] = d[5:0];
  endtask

  task automatic rd_chk(input logic [7:0] a, input logic [31:0] exp, input string req);
    @(negedge clk);
    addr = a;
    #1;
    chk(req, 64'(rdata), 64'(exp));
  endtask

  function automatic logic [31:0] step(input logic [31:0] x);
    logic [31:0] y;
    y = x ^ (x << 13);
    y = y ^ (y >> 17);
    return y ^ (y << 5);
  endfunction

  task automatic sweep(input string req);
    for (int idx = 0; idx < 96; idx++) begin
      int ln;
      ln = idx % 32;
      if ((idx < 32 && ln >= 14) || (idx >= 32 && idx < 64 && ln >= 24)) continue;
      @(negedge clk);
      b0 = '0; b1 = '0; b2 = '0;
      if (idx < 32) b0[ln] = 1'b1;
      else if (idx < 64) b1[ln] = 1'b1;
      else b2[ln] = 1'b1;
      out_chk(req);
    end
    for (int v = 0; v < 40; v++) begin
      @(negedge clk);
      lfsr = step(lfsr); b0 = lfsr[13:0];
      lfsr = step(lfsr); b1 = lfsr[23:0];
      lfsr = step(lfsr); b2 = lfsr;
      out_chk(req);
    end
    @(negedge clk);
    b0 = '0; b1 = '0; b2 = '0;
    out_chk("R11 all inputs low");
  endtask

  initial begin
    #(8 * 150000);
    bad++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    rd_chk(8'h54, 32'h0, "R1 word0 reset");
    rd_chk(8'h58, 32'h0, "R1 word1 reset");
    sweep("R1 R2 R3 R7 default routing");

    // R2 R3 R5 R6 R7 all slots on bank 2, R4 tail slots quiet
    wr(8'h54, 32'hFFFF_FFFF);
    wr(8'h58, 32'hFFFF_FFFF);
    rd_chk(8'h58, 32'h0000_003F, "R8 word1 upper bits read 0");
    rd_chk(8'h54, 32'hFFFF_FFFF, "R8 word0 readback");
    sweep("R2 R3 R4 R5 R6 all select");

    wr(8'h54, 32'hAAAA_AAAA);
    wr(8'h58, 32'h0000_002A);
    sweep("R2 R3 R4 R5 R6 R7 alternating");
    wr(8'h54, 32'h5555_5555);
    wr(8'h58, 32'h0000_0015);
    sweep("R2 R3 R4 R5 R6 R7 alternating inverse");
    wr(8'h54, 32'h0000_3FFF);
    wr(8'h58, 32'h0);
    sweep("R2 R5 R7 bank0 group only");
    wr(8'h54, 32'hFFFF_C000);
    wr(8'h58, 32'h0000_003F);
    sweep("R3 R4 R6 R7 bank1 group only");

    // R9 stray address
    wr(8'h54, 32'h1234_5678);
    wr(8'h58, 32'h0000_0021);
    wr(8'h50, 32'hFFFF_FFFF);
    wr(8'h5C, 32'hFFFF_FFFF);
    rd_chk(8'h54, 32'h1234_5678, "R9 word0 after stray write");
    rd_chk(8'h58, 32'h0000_0021, "R9 word1 after stray write");
    rd_chk(8'h50, 32'h0, "R9 stray read");
    sweep("R9 routing after stray write");

    // R10 write and input change in the same cycle
    wr(8'h54, 32'h0);
    wr(8'h58, 32'h0);
    @(negedge clk);
    b0 = 14'h1; b1 = '0; b2 = '0;
    addr = 8'h54; wdata = 32'h1; we = 1'b1;
    #1;
    chk("R10 old routing before edge", 64'({shared, direct}), 64'({3'b000, 38'h1}));
    @(posedge clk);
    #1;
    chk("R10 new routing after edge", 64'({shared, direct}), 64'({3'b001, 38'h0}));
    @(negedge clk);
    we = 1'b0;
    b0 = '0;

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule